// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product. It recodes the multiplier in radix 4, so it needs only half as many partial products as a plain shift-and-add multiplier.

Each overlapping three-bit window of the multiplier drives five mutually exclusive select lines. Each select line picks one multiple of the multiplicand: zero, one, two, minus one or minus two. Every partial product is built in the same cycle from the multiplicand by a few word transforms: pass, shift left, invert and force to zero. The "+1" that completes a negation is held back as a carry bit.

A chain of registered stages then adds one partial product per stage. Each stage uses a ripple adder whose carry is a three-input majority and whose sum bit is picked by that carry. A new operand pair can enter on every clock edge. A valid flag travels with the data. `WIDTH` must be even.

Top module: `booth_mult_pipe`

## Requirements
- R1: When an operand pair is accepted, `product` later equals the signed product `mcand * mplier`, exact over its `2*WIDTH` bits.
- R2: Multiplier bit pair group `g` reads the window {mplier[2g+1], mplier[2g], mplier[2g-1]}, with mplier[-1] taken as 0. The window maps as follows: 000 or 111 selects zero, 001 or 010 selects +1, 011 selects +2, 100 selects -2, and 101 or 110 selects -1. Exactly one of the five select lines is high for an accepted pair.
- R3: The zero select gives an all-zero partial product with no carry. A negative select gives the bitwise inverse of the sign-extended (and, for -2, doubled) multiplicand, plus a carry of one. All partial products of one pair are formed in the cycle the pair is accepted.
- R4: A pair sampled with `in_valid` high on rising edge e gives `out_valid` high and the matching `product` right after edge e + WIDTH/2. That is the (WIDTH/2 + 1)th edge counting e, which is the 9th edge at the default width.
- R5: Pairs on consecutive edges are all accepted, and each yields its own correct product on consecutive cycles.
- R6: A cycle with `in_valid` low yields `out_valid` low WIDTH/2 edges later, whatever operands are present.
- R7: Each pipeline stage adds one aligned partial product to the running sum. Partial product g is shifted left by 2g bits, and its negation carry enters at bit 2g. Each adder bit forms its carry as the majority of its three inputs and its sum as the AND of the three inputs when that carry is 1, else their OR.
- R8: While `rst_n` is low, and on the cycles straight after its release before any accepted pair has travelled the pipeline, `out_valid` is low.
- R9: Extreme operands are exact, including the most negative value times itself, which gives 2^(2*WIDTH-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier (recoded) |
| out_valid | output | 1 | Product present this cycle |
| product | output | 2*WIDTH | Signed product |

## Verification
Each accepted pair's product and valid flag are due exactly WIDTH/2 rising edges after the edge that samples the pair. The bench stores the expected result for every edge in a small ring indexed by edge number. After each edge it reads, at the falling edge, the entry written WIDTH/2 edges earlier, so gaps in `in_valid` are checked at the same place as real results. A 6-bit instance is swept over all 4096 operand pairs back to back, with bubble patterns in between. A default-width instance runs in parallel on extreme and pseudo-random operands, with its own WIDTH/2 offset.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

    // One-hot choice of multiplicand multiple for one radix-4 group
    typedef struct packed {
        logic neg_two;
        logic neg_one;
        logic two;
        logic one;
        logic zero;
    } booth_sel_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mult_pkg::*;
(
    input  logic [2:0] window,   // {y[2g+1], y[2g], y[2g-1]}
    output booth_sel_t sel
);

    always_comb begin
        sel = '0;
        unique case (window)
            3'b000, 3'b111: sel.zero    = 1'b1;
            3'b001, 3'b010: sel.one     = 1'b1;
            3'b011:         sel.two     = 1'b1;
            3'b100:         sel.neg_two = 1'b1;
            default:        sel.neg_one = 1'b1;  // 101, 110
        endcase
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_mult_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32,
    parameter int SHIFT = 0
) (
    input  logic [IN_W-1:0]  mcand,
    input  booth_sel_t       sel,
    output logic [OUT_W-1:0] pp,     // aligned by SHIFT, sign-extended
    output logic             inc     // pending +1 for a negation
);

    logic [OUT_W-1:0] ext;
    logic [OUT_W-1:0] word;

    assign ext = {{(OUT_W-IN_W){mcand[IN_W-1]}}, mcand};

    always_comb begin
        word = '0;
        if (sel.one | sel.neg_one) word = ext;         // keep
        if (sel.two | sel.neg_two) word = ext << 1;    // shift left
        if (sel.neg_one | sel.neg_two) word = ~word;   // invert
        if (sel.zero) word = '0;                       // force zero
        inc = sel.neg_one | sel.neg_two;               // add-one deferred
        pp  = word << SHIFT;
    end

endmodule

// File: rtl/maj_ripple_adder.sv
module maj_ripple_adder #(
    parameter int WD      = 32,
    parameter int CIN_POS = 0     // bit where the carry-in is injected
) (
    input  logic [WD-1:0] a,
    input  logic [WD-1:0] b,
    input  logic          cin,
    output logic [WD-1:0] sum
);

    always_comb begin
        logic cy;
        logic co;
        cy  = 1'b0;
        co  = 1'b0;
        sum = '0;
        for (int i = 0; i < WD; i++) begin
            if (i == CIN_POS) cy = cin;
            co     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
            sum[i] = co ? (a[i] & b[i] & cy) : (a[i] | b[i] | cy);
            cy     = co;
        end
    end

endmodule

// File: rtl/booth_mult_pipe.sv
module booth_mult_pipe
    import booth_mult_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW  = 2 * WIDTH;
    localparam int NPP = WIDTH / 2;

    // ---------------- recoding and partial products ----------------
    logic [WIDTH:0]             mplier_x;
    booth_sel_t                 sel_w  [NPP];
    logic [NPP-1:0][PW-1:0]     pp_all;
    logic [NPP-1:0]             inc_all;

    assign mplier_x = {mplier, 1'b0};

    for (genvar g = 0; g < NPP; g++) begin : grp
        booth_recoder u_rec (
            .window (mplier_x[2*g+2 -: 3]),
            .sel    (sel_w[g])
        );
        booth_pp_gen #(.IN_W(WIDTH), .OUT_W(PW), .SHIFT(2*g)) u_pp (
            .mcand  (mcand),
            .sel    (sel_w[g]),
            .pp     (pp_all[g]),
            .inc    (inc_all[g])
        );

        p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> $onehot(sel_w[g]));
        p_neg_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (inc_all[g] == (sel_w[g].neg_one | sel_w[g].neg_two)));
        p_zero_pp_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel_w[g].zero) |-> (pp_all[g] == '0 && !inc_all[g]));
    end

    // ---------------- accumulation stages ----------------
    for (genvar s = 0; s < NPP; s++) begin : stg
        localparam int NREM = NPP - s;

        logic                     vld_d, vld_q;
        logic [PW-1:0]            acc_d, acc_q;
        logic [NREM-1:0][PW-1:0]  pp_d,  pp_q;
        logic [NREM-1:0]          inc_d, inc_q;
        logic [PW-1:0]            res;

        if (s == 0) begin : g_head
            always_comb begin
                vld_d = in_valid;
                acc_d = '0;
                pp_d  = pp_all;
                inc_d = inc_all;
            end
        end else begin : g_body
            always_comb begin
                vld_d = stg[s-1].vld_q;
                acc_d = stg[s-1].res;
                pp_d  = stg[s-1].pp_q[NREM:1];
                inc_d = stg[s-1].inc_q[NREM:1];
            end

            p_vld_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q == $past(stg[s-1].vld_q));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                acc_q <= '0;
                pp_q  <= '0;
                inc_q <= '0;
            end else begin
                vld_q <= vld_d;
                acc_q <= acc_d;
                pp_q  <= pp_d;
                inc_q <= inc_d;
            end
        end

        maj_ripple_adder #(.WD(PW), .CIN_POS(2*s)) u_add (
            .a   (acc_q),
            .b   (pp_q[0]),
            .cin (inc_q[0]),
            .sum (res)
        );

        p_stage_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
            res == PW'(acc_q + pp_q[0] + (PW'(inc_q[0]) << (2*s))));
    end

    // ---------------- output register ----------------
    logic          out_vld_d, out_vld_q;
    logic [PW-1:0] prod_d,    prod_q;

    always_comb begin
        out_vld_d = stg[NPP-1].vld_q;
        prod_d    = stg[NPP-1].res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            prod_q    <= '0;
        end else begin
            out_vld_q <= out_vld_d;
            prod_q    <= prod_d;
        end
    end

    assign out_valid = out_vld_q;
    assign product   = prod_q;

    p_out_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(stg[NPP-1].vld_q));

endmodule

// File: tb/booth_mult_pipe_test.sv
`timescale 1ns/1ps
module booth_mult_pipe_test;

    localparam int SW = 6;
    localparam int LW = 16;
    localparam int NS = SW / 2;
    localparam int NL = LW / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              vs, vl, ovs, ovl;
    logic [SW-1:0]     as_i, bs_i;
    logic [LW-1:0]     al_i, bl_i;
    logic [2*SW-1:0]   ps_o;
    logic [2*LW-1:0]   pl_o;

    booth_mult_pipe #(.WIDTH(SW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(vs), .mcand(as_i), .mplier(bs_i),
        .out_valid(ovs), .product(ps_o));

    booth_mult_pipe #(.WIDTH(LW)) uut_w (
        .clk(clk), .rst_n(rst_n), .in_valid(vl), .mcand(al_i), .mplier(bl_i),
        .out_valid(ovl), .product(pl_o));

    int checks = 0;
    int errors = 0;
    int t = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    logic              rv_s [16];
    logic [2*SW-1:0]   rp_s [16];
    string             rt_s [16];
    logic              rv_l [16];
    logic [2*LW-1:0]   rp_l [16];
    string             rt_l [16];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // one clock: drive, record expectations, check outputs due now
    task automatic step(input logic v_s, input logic signed [SW-1:0] a_s,
                        input logic signed [SW-1:0] b_s, input string tag_s,
                        input logic v_l, input logic signed [LW-1:0] a_l,
                        input logic signed [LW-1:0] b_l, input string tag_l);
        logic signed [2*SW-1:0] es;
        logic signed [2*LW-1:0] el;
        logic ev;
        int   k;
        vs = v_s; as_i = a_s; bs_i = b_s;
        vl = v_l; al_i = a_l; bl_i = b_l;
        es = a_s * b_s;
        el = a_l * b_l;
        rv_s[t % 16] = v_s; rp_s[t % 16] = es; rt_s[t % 16] = tag_s;
        rv_l[t % 16] = v_l; rp_l[t % 16] = el; rt_l[t % 16] = tag_l;
        @(posedge clk);
        @(negedge clk);
        // small instance: result due NS edges after sampling edge
        ev = 1'b0;
        if (t >= NS) begin
            k  = (t - NS) % 16;
            ev = rv_s[k];
            if (ev) check(ps_o == rp_s[k], rt_s[k], "small product", ps_o, rp_s[k]);
        end
        check(ovs == ev, ev ? "R4" : "R6", "small out_valid", ovs, ev);
        // wide instance: result due NL edges after sampling edge
        ev = 1'b0;
        if (t >= NL) begin
            k  = (t - NL) % 16;
            ev = rv_l[k];
            if (ev) check(pl_o == rp_l[k], rt_l[k], "wide product", pl_o, rp_l[k]);
        end
        check(ovl == ev, ev ? "R4" : "R6", "wide out_valid", ovl, ev);
        t++;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
        finish_run();
    end

    initial begin
        logic signed [LW-1:0] cl_a [8];
        logic signed [LW-1:0] cl_b [8];
        for (int i = 0; i < 16; i++) begin
            rv_s[i] = 1'b0; rp_s[i] = '0; rt_s[i] = "";
            rv_l[i] = 1'b0; rp_l[i] = '0; rt_l[i] = "";
        end
        cl_a[0] = 16'sh8000; cl_b[0] = 16'sh8000;
        cl_a[1] = 16'sh8000; cl_b[1] = 16'sh7fff;
        cl_a[2] = 16'sh7fff; cl_b[2] = 16'sh7fff;
        cl_a[3] = 16'shffff; cl_b[3] = 16'shffff;
        cl_a[4] = 16'sh0000; cl_b[4] = 16'sh8000;
        cl_a[5] = 16'sh7fff; cl_b[5] = 16'sh8000;
        cl_a[6] = 16'shaaaa; cl_b[6] = 16'sh5555;
        cl_a[7] = 16'sh8000; cl_b[7] = 16'shffff;

        // R8: outputs quiet under reset even with in_valid driven high
        vs = 1'b1; as_i = '1; bs_i = '1;
        vl = 1'b1; al_i = '1; bl_i = '1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(ovs == 1'b0, "R8", "small out_valid in reset", ovs, 0);
            check(ovl == 1'b0, "R8", "wide out_valid in reset", ovl, 0);
        end
        rst_n = 1'b1;

        // R1/R2/R3/R5/R7: every 6-bit pair back to back; wide gets random data
        for (int a = -32; a < 32; a++) begin
            for (int b = -32; b < 32; b++) begin
                lfsr = next_rand(lfsr);
                step(1'b1, SW'(a), SW'(b), "R1/R2/R3/R5/R7",
                     1'b1, lfsr[31:16], lfsr[15:0], "R1/R5");
            end
        end

        // R6 bubbles on the small instance, R9 extremes on the wide one
        for (int i = 0; i < 96; i++) begin
            step(i % 3 == 0, SW'(i * 5 - 31), SW'(31 - i * 7), "R6/R1",
                 i % 2 == 0, cl_a[(i / 2) % 8], cl_b[(i / 2) % 8], "R9");
        end

        // drain with in_valid low: no stray valid allowed (R6)
        for (int i = 0; i < NL + 3; i++) begin
            step(1'b0, '1, '1, "R6", 1'b0, '1, '1, "R6");
        end

        finish_run();
    end

endmodule